// File: doc/BRIEF.md
# Pointer/Data Word Sender

This block moves words to a peer across a shared parallel bus that is captured by an external latch. A local requester offers either a full destination address or a single data word through a valid/ready port. An address is twice the bus word width, so it goes out as two bus words, upper half first. Each bus word is written into the latch with a one-cycle setup phase and then a one-cycle write strobe. After that the block signals the peer on its outgoing notify line.

The level of the notify line tells the peer what kind of word it is. For an address word the line goes high and stays high until the peer acknowledges. For a data word the line gives a short high pulse and then returns low, so the peer samples a low level. The acknowledge from the peer is asynchronous to the block. It passes through a two-flop synchronizer, and only its rising edge counts. No word starts before the previous word has been acknowledged.

An early-notify mode can be selected for each request. In this mode the notify line rises during the latch setup cycle instead of after the strobe. This relies on the peer needing several cycles to react: the `REACT_LAT` parameter gives that reaction time, and the mode is disabled whenever `REACT_LAT` is shorter than the two-cycle bus write.

Top module: `ptr_word_tx`

## Requirements
- R1: While reset is asserted, and after it is released, `bus_sel`, `bus_wr` and `peer_rd` are low and `req_ready` is high.
- R2: `req_ready` is high only when no transfer is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While busy, `req_valid` is ignored and the payload already taken does not change.
- R3: Each bus word is one setup cycle (`bus_sel`=1, `bus_wr`=0) followed by one strobe cycle (`bus_sel`=1, `bus_wr`=1), with `bus_data` stable across both.
- R4: For a data word (`req_is_addr`=0), `bus_data` carries `req_payload[WORD_W-1:0]`. In normal mode `peer_rd` is high for exactly `PULSE_CYC` cycles right after the strobe, then low while the block waits for the acknowledge.
- R5: For an address (`req_is_addr`=1), the block sends `req_payload[2*WORD_W-1:WORD_W]` first and `req_payload[WORD_W-1:0]` second. After each strobe `peer_rd` stays high until the acknowledge is recognised.
- R6: Only a rising edge of `peer_ack` ends the wait. It takes effect on the third clock edge after the rise. Without a new rising edge the block never advances, even if `peer_ack` is held high.
- R7: Between the two words of an address, `peer_rd` and `bus_sel` are low for one cycle, so the second word produces a fresh rising edge on `peer_rd`.
- R8: In early mode (`early_mode`=1 at acceptance), `peer_rd` is already high in the setup and strobe cycles. A data word then drops it right after the strobe; an address word holds it until the acknowledge.
- R9: `early_mode` is sampled only when a request is taken. Changing it during a transfer has no effect on that transfer.
- R10: An acknowledge edge that arrives before the wait phase of the current word (during setup, strobe or pulse) is remembered. The block leaves the wait phase one cycle after entering it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_is_addr | input | 1 | 1: payload is an address, 0: data word in the low half |
| req_payload | input | 2*WORD_W | Address, or data in bits WORD_W-1:0 |
| early_mode | input | 1 | Raise the notify line during the latch write |
| req_ready | output | 1 | Idle, request can be taken |
| bus_data | output | WORD_W | Word presented to the external latch |
| bus_sel | output | 1 | Latch access active (setup and strobe cycles) |
| bus_wr | output | 1 | Latch write strobe |
| peer_rd | output | 1 | Notify line to the peer; its level encodes the word type |
| peer_ack | input | 1 | Asynchronous acknowledge from the peer |

## Verification
The bench builds the block with its defaults: 16-bit words, a one-cycle data pulse and a reaction time of six cycles. That reaction time keeps early-notify mode enabled, so both the normal and early signalling sequences can be reached, for data words and for both halves of an address. A single-cycle pulse makes the notify high time exactly countable. The three-edge acknowledge path gives room to raise the acknowledge inside the setup cycle, which exercises the remembered-acknowledge path, and to hold it high across a whole transfer.

// File: rtl/ptr_word_pkg.sv
package ptr_word_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_PULSE  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_REARM  = 3'd5
  } tx_state_e;

  localparam int unsigned BUS_WRITE_CYC = 2;
endpackage

// File: rtl/ptr_word_ack_sync.sv
module ptr_word_ack_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async,
  output logic ack_rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ack_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign ack_rise = s2_q & ~s3_q;
endmodule

// File: rtl/ptr_word_seq.sv
module ptr_word_seq
  import ptr_word_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned REACT_LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_is_addr,
  input  logic early_req,
  input  logic ack_rise,
  output logic req_ready,
  output logic take,
  output logic is_addr,
  output logic second,
  output logic sel,
  output logic wr,
  output logic rd
);
  localparam bit EARLY_OK = (REACT_LAT >= BUS_WRITE_CYC);
  localparam int unsigned CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_CYC - 1);

  tx_state_e state_q, state_d;
  logic addr_q, addr_d;
  logic early_q, early_d;
  logic second_q, second_d;
  logic pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    early_d  = early_q;
    second_d = second_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_SETUP;
          addr_d   = req_is_addr;
          early_d  = early_req & EARLY_OK;
          second_d = 1'b0;
          pend_d   = 1'b0;
        end
      end
      ST_SETUP: begin
        state_d = ST_STROBE;
        if (ack_rise) pend_d = 1'b1;
      end
      ST_STROBE: begin
        cnt_d = '0;
        if (addr_q || early_q) state_d = ST_WAIT;
        else                   state_d = ST_PULSE;
        if (ack_rise) pend_d = 1'b1;
      end
      ST_PULSE: begin
        if (cnt_q == CNT_LAST) state_d = ST_WAIT;
        else                   cnt_d   = cnt_q + 1'b1;
        if (ack_rise) pend_d = 1'b1;
      end
      ST_WAIT: begin
        if (ack_rise || pend_q) begin
          pend_d = 1'b0;
          if (addr_q && !second_q) begin
            state_d  = ST_REARM;
            second_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REARM: begin
        state_d = ST_SETUP;
        if (ack_rise) pend_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= 1'b0;
      early_q  <= 1'b0;
      second_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      early_q  <= early_d;
      second_q <= second_d;
      pend_q   <= pend_d;
      cnt_q    <= cnt_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_ready & req_valid;
  assign is_addr   = addr_q;
  assign second    = second_q;
  assign sel       = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign wr        = (state_q == ST_STROBE);
  assign rd        = (early_q && sel) || (state_q == ST_PULSE) ||
                     (addr_q && state_q == ST_WAIT);
endmodule

// File: rtl/ptr_word_mux.sv
module ptr_word_mux #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [2*WORD_W-1:0]   payload,
  input  logic                  is_addr,
  input  logic                  second,
  output logic [WORD_W-1:0]     word
);
  logic [2*WORD_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= payload;
  end

  assign word = (is_addr && !second) ? hold_q[2*WORD_W-1:WORD_W]
                                     : hold_q[WORD_W-1:0];
endmodule

// File: rtl/ptr_word_tx.sv
module ptr_word_tx #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned REACT_LAT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_is_addr,
  input  logic [2*WORD_W-1:0] req_payload,
  input  logic                early_mode,
  output logic                req_ready,
  output logic [WORD_W-1:0]   bus_data,
  output logic                bus_sel,
  output logic                bus_wr,
  output logic                peer_rd,
  input  logic                peer_ack
);
  logic rst_m_q, rst_i_q;
  logic ack_rise, take, is_addr, second;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i_q <= rst_m_q;
    end
  end

  ptr_word_ack_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_i_q),
    .ack_async(peer_ack),
    .ack_rise (ack_rise)
  );

  ptr_word_seq #(.PULSE_CYC(PULSE_CYC), .REACT_LAT(REACT_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_q),
    .req_valid  (req_valid),
    .req_is_addr(req_is_addr),
    .early_req  (early_mode),
    .ack_rise   (ack_rise),
    .req_ready  (req_ready),
    .take       (take),
    .is_addr    (is_addr),
    .second     (second),
    .sel        (bus_sel),
    .wr         (bus_wr),
    .rd         (peer_rd)
  );

  ptr_word_mux #(.WORD_W(WORD_W)) u_mux (
    .clk    (clk),
    .rst_n  (rst_i_q),
    .load   (take),
    .payload(req_payload),
    .is_addr(is_addr),
    .second (second),
    .word   (bus_data)
  );
endmodule

// File: rtl/ptr_word_tx_chk.sv
module ptr_word_tx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [WORD_W-1:0] bus_data,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              peer_rd
);
  AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_sel); // R3
  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> ($past(bus_sel) && !$past(bus_wr))); // R3
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr); // R3
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && $past(bus_sel)) |-> $stable(bus_data)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_sel && !peer_rd)); // R2
  AST_BUSY_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R2
endmodule

bind ptr_word_tx ptr_word_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .bus_data (bus_data),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .peer_rd  (peer_rd)
);

// File: tb/sim_ptr_word_tx.sv
`timescale 1ns/1ps
module sim_ptr_word_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_addr, early_mode, peer_ack;
  logic [31:0] req_payload;
  logic        req_ready, bus_sel, bus_wr, peer_rd;
  logic [15:0] bus_data;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ptr_word_tx u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_addr(req_is_addr),
    .req_payload(req_payload), .early_mode(early_mode), .req_ready(req_ready),
    .bus_data(bus_data), .bus_sel(bus_sel), .bus_wr(bus_wr), .peer_rd(peer_rd),
    .peer_ack(peer_ack)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic a, input logic e, input logic [31:0] p);
    req_valid = 1'b1; req_is_addr = a; early_mode = e; req_payload = p;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic ack_done(input string req);
    peer_ack = 1'b1;
    tick(); tick();
    chk(req, "ready before third edge", req_ready, 1'b0);
    tick();
    chk(req, "ready after ack", req_ready, 1'b1);
    chk(req, "rd idle", peer_rd, 1'b0);
    peer_ack = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 0; req_is_addr = 0; early_mode = 0;
    peer_ack = 0; req_payload = '0;
    repeat (3) tick();
    chk("R1", "rd in reset", peer_rd, 1'b0);
    chk("R1", "wr in reset", bus_wr, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", "ready", req_ready, 1'b1);
    chk("R1", "sel", bus_sel, 1'b0);
    chk("R1", "rd", peer_rd, 1'b0);
  endtask

  task automatic t_data_normal();
    send(1'b0, 1'b0, 32'h0000_A5C3);
    chk("R3", "setup sel", bus_sel, 1'b1);
    chk("R3", "setup wr", bus_wr, 1'b0);
    chk("R4", "setup rd", peer_rd, 1'b0);
    chk("R4", "data word", bus_data, 16'hA5C3);
    chk("R2", "busy", req_ready, 1'b0);
    tick();
    chk("R3", "strobe wr", bus_wr, 1'b1);
    chk("R3", "strobe data", bus_data, 16'hA5C3);
    tick();
    chk("R4", "pulse rd", peer_rd, 1'b1);
    chk("R4", "pulse sel", bus_sel, 1'b0);
    tick();
    chk("R4", "rd low in wait", peer_rd, 1'b0);
    repeat (4) tick();
    chk("R6", "no ack holds", req_ready, 1'b0);
    ack_done("R6");
  endtask

  task automatic t_addr_normal();
    send(1'b1, 1'b0, 32'h1234_5678);
    chk("R5", "upper half first", bus_data, 16'h1234);
    chk("R5", "setup rd", peer_rd, 1'b0);
    tick();
    chk("R3", "strobe", bus_wr, 1'b1);
    tick();
    chk("R5", "rd raised", peer_rd, 1'b1);
    req_valid = 1'b1; req_payload = 32'hFFFF_FFFF; req_is_addr = 1'b0;
    repeat (3) tick();
    chk("R5", "rd held", peer_rd, 1'b1);
    peer_ack = 1'b1;
    tick(); tick();
    chk("R5", "rd held to ack", peer_rd, 1'b1);
    tick();
    chk("R7", "gap rd", peer_rd, 1'b0);
    chk("R7", "gap sel", bus_sel, 1'b0);
    chk("R2", "busy in gap", req_ready, 1'b0);
    peer_ack = 1'b0;
    tick();
    req_valid = 1'b0;
    chk("R5", "lower half second", bus_data, 16'h5678);
    chk("R2", "payload kept", bus_data, 16'h5678);
    tick();
    chk("R3", "second strobe", bus_wr, 1'b1);
    tick();
    chk("R5", "rd raised again", peer_rd, 1'b1);
    repeat (3) tick();
    ack_done("R5");
  endtask

  task automatic t_data_early();
    send(1'b0, 1'b1, 32'h0000_0F0F);
    chk("R8", "rd in setup", peer_rd, 1'b1);
    chk("R8", "no strobe yet", bus_wr, 1'b0);
    tick();
    chk("R8", "rd in strobe", peer_rd, 1'b1);
    chk("R3", "strobe", bus_wr, 1'b1);
    tick();
    chk("R8", "rd low after", peer_rd, 1'b0);
    ack_done("R8");
  endtask

  task automatic t_addr_early();
    send(1'b1, 1'b1, 32'hCAFE_BEEF);
    chk("R8", "rd in setup", peer_rd, 1'b1);
    chk("R5", "upper half", bus_data, 16'hCAFE);
    tick(); tick();
    chk("R8", "rd held", peer_rd, 1'b1);
    peer_ack = 1'b1;
    repeat (3) tick();
    chk("R7", "gap rd early", peer_rd, 1'b0);
    peer_ack = 1'b0;
    tick();
    chk("R8", "rd second setup", peer_rd, 1'b1);
    chk("R5", "lower half", bus_data, 16'hBEEF);
    tick(); tick();
    chk("R8", "rd held second", peer_rd, 1'b1);
    ack_done("R8");
  endtask

  task automatic t_early_ack();
    peer_ack = 1'b1;
    send(1'b0, 1'b0, 32'h0000_1111);
    tick(); tick();
    chk("R10", "pulse still given", peer_rd, 1'b1);
    tick();
    chk("R10", "in wait", req_ready, 1'b0);
    tick();
    chk("R10", "remembered ack", req_ready, 1'b1);
    peer_ack = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_mode_latched();
    send(1'b0, 1'b0, 32'h0000_2222);
    early_mode = 1'b1;
    chk("R9", "setup rd", peer_rd, 1'b0);
    tick();
    chk("R9", "strobe rd", peer_rd, 1'b0);
    tick();
    chk("R9", "pulse rd", peer_rd, 1'b1);
    early_mode = 1'b0;
    tick();
    ack_done("R9");
  endtask

  task automatic t_ack_level();
    peer_ack = 1'b1;
    repeat (5) tick();
    send(1'b0, 1'b0, 32'h0000_3333);
    repeat (8) tick();
    chk("R6", "held ack ignored", req_ready, 1'b0);
    peer_ack = 1'b0;
    repeat (3) tick();
    ack_done("R6");
  endtask

  task automatic t_reset_mid();
    send(1'b1, 1'b0, 32'h0101_0202);
    tick(); tick();
    chk("R1", "rd before reset", peer_rd, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "rd cleared async", peer_rd, 1'b0);
    chk("R1", "ready in reset", req_ready, 1'b1);
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", "idle after", bus_sel, 1'b0);
  endtask

  initial begin
    t_reset();
    t_data_normal();
    t_addr_normal();
    t_data_early();
    t_addr_early();
    t_early_ack();
    t_mode_latched();
    t_ack_level();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule